// File: doc/BRIEF.md
# Converter Busy and Calibration Timer

This block is the timing model of the control side of a sampling converter. A conversion starts on a rising edge of the convert-start pin or on a one-cycle software request. The block then holds its busy output high for a fixed number of master-clock cycles. A rising edge on the calibration request line starts a calibration instead. Busy then stays high for the much longer cycle count of the calibration type chosen by a two-bit select. As busy falls, a one-cycle done pulse fires. Sample data, the analog path and the serial port are not part of the block.

Some requests arrive while busy is high. A conversion request during a conversion is dropped, and it sets a sticky overrun flag. A conversion request during a calibration is held in a one-deep slot and starts right after the calibration ends. A second such request while the slot is full counts as overrun. Calibration requests that arrive while busy are dropped. After reset nothing runs until a fresh low-to-high transition is seen.

Top module: `conv_busy_timer`

## Requirements
- R1: A rising edge on `convst_i` seen while idle sets `busy_o` high from the next clock cycle, for exactly `CONV_CYC` cycles (default 18).
- R2: A rising edge on `cal_i` seen while idle sets `busy_o` high from the next clock cycle. The length follows `cal_sel_i` at that edge: 0 gives `SELF_CAL_CYC` (default 125013), 1 gives `GAIN_CAL_CYC` (default 111114), 2 gives `OFFS_CAL_CYC` (default 13899), and 3 gives `SELF_CAL_CYC`.
- R3: `done_o` is high for exactly one cycle, the first cycle in which `busy_o` is low after an operation, and it is never high at any other time.
- R4: A conversion request that arrives while a conversion runs, including its final cycle, is ignored. The running conversion keeps its length, no further conversion follows, and `overrun_o` goes high and stays high until reset.
- R5: A conversion request that arrives while a calibration runs is held, and so is one that arrives in the same cycle a calibration is accepted. It also counts as held when it lands in the calibration's final cycle. After the calibration, `busy_o` is low for exactly one cycle and then high for `CONV_CYC` cycles. A second conversion request while one is held sets `overrun_o`.
- R6: A rising edge on `cal_i` while `busy_o` is high is ignored. The running operation keeps its length and no calibration follows.
- R7: Reset clears `busy_o`, `done_o` and `overrun_o`. An input that is already high when reset is released starts nothing; only a later low-to-high transition does.
- R8: A request seen in the done cycle starts the next operation at once, so `busy_o` is low for exactly one cycle between the two operations.
- R9: `sw_conv_i` is sampled every cycle, and each cycle in which it is high counts as one conversion request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| convst_i | input | 1 | Convert-start pin, acts on its rising edge |
| sw_conv_i | input | 1 | Software conversion request, one request per high cycle |
| cal_i | input | 1 | Calibration request, acts on its rising edge |
| cal_sel_i | input | 2 | Calibration type: 0 full self, 1 full-scale, 2 offset, 3 full self |
| busy_o | output | 1 | High while a conversion or calibration is in progress |
| done_o | output | 1 | One-cycle pulse in the cycle busy falls |
| overrun_o | output | 1 | Sticky flag for dropped conversion requests |

## Verification
Two functions can fall in the same cycle. In one, a calibration reaches its final cycle just as a conversion request arrives. In the other, a calibration request and a conversion request arrive together while the block is idle. The bench moves a software request across every cycle of an offset calibration, the last one included, and also drives both request lines on the same edge. It then checks that the calibration length is untouched. It also checks that busy drops for exactly one cycle while done is high, and that the queued conversion then runs its full length with no overrun. The same position sweep over a conversion checks that a request landing on the final cycle is dropped with overrun rather than queued.

// File: rtl/conv_timer_pkg.sv
package conv_timer_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CONV = 2'd1,
        ST_CAL  = 2'd2
    } ctl_state_e;

    typedef enum logic [1:0] {
        CAL_SELF_FULL = 2'd0,
        CAL_SYS_GAIN  = 2'd1,
        CAL_SYS_OFFS  = 2'd2,
        CAL_SELF_ALT  = 2'd3
    } cal_kind_e;

    // Requests seen in one cycle, after edge detection
    typedef struct packed {
        logic conv;
        logic cal;
    } req_t;

    localparam int EDGE_LINES = 2;
    localparam int EDGE_CONV  = 0;
    localparam int EDGE_CAL   = 1;

    function automatic int unsigned cal_cycles(input cal_kind_e kind,
                                               input int unsigned self_c,
                                               input int unsigned gain_c,
                                               input int unsigned offs_c);
        int unsigned r;
        case (kind)
            CAL_SYS_GAIN: r = gain_c;
            CAL_SYS_OFFS: r = offs_c;
            default:      r = self_c;
        endcase
        return r;
    endfunction

    function automatic int unsigned max_of4(input int unsigned a, input int unsigned b,
                                            input int unsigned c, input int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/edge_rise.sv
module edge_rise #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] sig_i,
    output logic [N-1:0] rise_o
);
    logic [N-1:0] prev_q;

    for (genvar i = 0; i < N; i++) begin : g_line
        // During reset the history follows the pin, so a level held
        // through reset release is not an edge.
        always_ff @(posedge clk) begin
            prev_q[i] <= sig_i[i];
        end
        assign rise_o[i] = sig_i[i] & ~prev_q[i] & ~rst;
    end
endmodule

// File: rtl/op_down_counter.sv
module op_down_counter #(
    parameter int CNT_W = 17
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             expired_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/op_sequencer.sv
module op_sequencer
    import conv_timer_pkg::*;
#(
    parameter int          CNT_W        = 17,
    parameter int unsigned CONV_CYC     = 18,
    parameter int unsigned SELF_CAL_CYC = 125013,
    parameter int unsigned GAIN_CAL_CYC = 111114,
    parameter int unsigned OFFS_CAL_CYC = 13899
) (
    input  logic             clk,
    input  logic             rst,
    input  req_t             req_i,
    input  logic [1:0]       cal_sel_i,
    input  logic             expired_i,
    output logic             load_o,
    output logic [CNT_W-1:0] load_val_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             overrun_o
);
    localparam logic [CNT_W-1:0] CONV_LOAD = CNT_W'(CONV_CYC - 1);

    ctl_state_e       state_q, state_d;
    logic             pend_q, pend_d;
    logic             ovr_q, ovr_d;
    logic             done_q, done_d;
    logic [CNT_W-1:0] cal_load;

    assign cal_load = CNT_W'(cal_cycles(cal_kind_e'(cal_sel_i), SELF_CAL_CYC,
                                        GAIN_CAL_CYC, OFFS_CAL_CYC) - 1);

    always_comb begin
        state_d    = state_q;
        pend_d     = pend_q;
        ovr_d      = ovr_q;
        done_d     = 1'b0;
        load_o     = 1'b0;
        load_val_o = CONV_LOAD;
        case (state_q)
            ST_IDLE: begin
                if (pend_q) begin
                    state_d = ST_CONV;
                    load_o  = 1'b1;
                    pend_d  = 1'b0;
                    if (req_i.conv) ovr_d = 1'b1;
                end else if (req_i.cal) begin
                    state_d    = ST_CAL;
                    load_o     = 1'b1;
                    load_val_o = cal_load;
                    pend_d     = req_i.conv;
                end else if (req_i.conv) begin
                    state_d = ST_CONV;
                    load_o  = 1'b1;
                end
            end
            ST_CONV: begin
                if (req_i.conv) ovr_d = 1'b1;
                if (expired_i) begin
                    state_d = ST_IDLE;
                    done_d  = 1'b1;
                end
            end
            ST_CAL: begin
                if (req_i.conv) begin
                    if (pend_q) ovr_d  = 1'b1;
                    else        pend_d = 1'b1;
                end
                if (expired_i) begin
                    state_d = ST_IDLE;
                    done_d  = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            pend_q  <= 1'b0;
            ovr_q   <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
            ovr_q   <= ovr_d;
            done_q  <= done_d;
        end
    end

    assign busy_o    = (state_q != ST_IDLE);
    assign done_o    = done_q;
    assign overrun_o = ovr_q;
endmodule

// File: rtl/conv_busy_timer.sv
module conv_busy_timer
    import conv_timer_pkg::*;
#(
    parameter int unsigned CONV_CYC     = 18,
    parameter int unsigned SELF_CAL_CYC = 125013,
    parameter int unsigned GAIN_CAL_CYC = 111114,
    parameter int unsigned OFFS_CAL_CYC = 13899
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       convst_i,
    input  logic       sw_conv_i,
    input  logic       cal_i,
    input  logic [1:0] cal_sel_i,
    output logic       busy_o,
    output logic       done_o,
    output logic       overrun_o
);
    localparam int unsigned LONGEST = max_of4(CONV_CYC, SELF_CAL_CYC, GAIN_CAL_CYC, OFFS_CAL_CYC);
    localparam int          CNT_W   = (LONGEST > 2) ? $clog2(LONGEST) : 1;

    logic [EDGE_LINES-1:0] pins;
    logic [EDGE_LINES-1:0] rises;
    req_t                  req;
    logic                  load;
    logic [CNT_W-1:0]      load_val;
    logic                  expired;

    assign pins[EDGE_CONV] = convst_i;
    assign pins[EDGE_CAL]  = cal_i;

    edge_rise #(.N(EDGE_LINES)) u_edge (
        .clk    (clk),
        .rst    (rst),
        .sig_i  (pins),
        .rise_o (rises)
    );

    assign req.conv = rises[EDGE_CONV] | (sw_conv_i & ~rst);
    assign req.cal  = rises[EDGE_CAL];

    op_sequencer #(
        .CNT_W        (CNT_W),
        .CONV_CYC     (CONV_CYC),
        .SELF_CAL_CYC (SELF_CAL_CYC),
        .GAIN_CAL_CYC (GAIN_CAL_CYC),
        .OFFS_CAL_CYC (OFFS_CAL_CYC)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .req_i      (req),
        .cal_sel_i  (cal_sel_i),
        .expired_i  (expired),
        .load_o     (load),
        .load_val_o (load_val),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .overrun_o  (overrun_o)
    );

    op_down_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .load_i     (load),
        .load_val_i (load_val),
        .expired_o  (expired)
    );
endmodule

// File: rtl/conv_busy_timer_chk.sv
module conv_busy_timer_chk #(
    parameter int unsigned CONV_CYC     = 18,
    parameter int unsigned SELF_CAL_CYC = 125013,
    parameter int unsigned GAIN_CAL_CYC = 111114,
    parameter int unsigned OFFS_CAL_CYC = 13899
) (
    input logic clk,
    input logic rst,
    input logic convst_i,
    input logic busy,
    input logic done,
    input logic overrun
);
    int unsigned run_len;

    always_ff @(posedge clk) begin
        if (rst)       run_len <= 0;
        else if (busy) run_len <= run_len + 1;
        else           run_len <= 0;
    end

    // R1 R2
    busy_len_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (run_len == CONV_CYC || run_len == SELF_CAL_CYC ||
                         run_len == GAIN_CAL_CYC || run_len == OFFS_CAL_CYC));

    // R3
    done_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    // R3
    done_only_fall_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> $fell(busy));

    // R4
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun);

    // R7
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!busy && !done && !overrun));

    // R1
    convst_start_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && $rose(convst_i)) |=> busy);
endmodule

bind conv_busy_timer conv_busy_timer_chk #(
    .CONV_CYC     (CONV_CYC),
    .SELF_CAL_CYC (SELF_CAL_CYC),
    .GAIN_CAL_CYC (GAIN_CAL_CYC),
    .OFFS_CAL_CYC (OFFS_CAL_CYC)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .convst_i (convst_i),
    .busy     (busy_o),
    .done     (done_o),
    .overrun  (overrun_o)
);

// File: tb/conv_busy_timer_bench.sv
module conv_busy_timer_bench;
    localparam int unsigned T_CONV = 5;
    localparam int unsigned T_SELF = 23;
    localparam int unsigned T_GAIN = 17;
    localparam int unsigned T_OFFS = 9;

    localparam int K_NONE = 0, K_SW = 1, K_PIN = 2, K_CAL = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       convst = 1'b0;
    logic       sw = 1'b0;
    logic       cal = 1'b0;
    logic [1:0] sel = 2'd0;
    logic       busy, done, ovr;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    conv_busy_timer #(
        .CONV_CYC     (T_CONV),
        .SELF_CAL_CYC (T_SELF),
        .GAIN_CAL_CYC (T_GAIN),
        .OFFS_CAL_CYC (T_OFFS)
    ) u_conv_busy_timer (
        .clk       (clk),
        .rst       (rst),
        .convst_i  (convst),
        .sw_conv_i (sw),
        .cal_i     (cal),
        .cal_sel_i (sel),
        .busy_o    (busy),
        .done_o    (done),
        .overrun_o (ovr)
    );

    function automatic int exp_cal_len(input int s);
        case (s)
            1:       return T_GAIN;
            2:       return T_OFFS;
            default: return T_SELF;
        endcase
    endfunction

    task automatic check_eq(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_all();
        convst = 1'b0;
        sw     = 1'b0;
        cal    = 1'b0;
    endtask

    task automatic drive(input int kind);
        if (kind == K_SW)  sw     = 1'b1;
        if (kind == K_PIN) convst = 1'b1;
        if (kind == K_CAL) cal    = 1'b1;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        clear_all();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    // Issue one request; returns at the first negedge where busy should be high.
    task automatic start(input int kind);
        drive(kind);
        @(negedge clk);
        clear_all();
    endtask

    // Count busy cycles, injecting requests at busy-cycle indices ia and ib.
    task automatic run_op(input int ia, input int ib, input int kind, output int len);
        len = 0;
        while (busy === 1'b1 && len < 100000) begin
            len++;
            clear_all();
            if (len == ia || len == ib) drive(kind);
            @(negedge clk);
        end
        clear_all();
    endtask

    task automatic idle_for(input string req, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check_eq(req, busy, 0);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        int len;
        do_reset();
        // R7 reset state
        check_eq("R7 busy after reset", busy, 0);
        check_eq("R7 done after reset", done, 0);
        check_eq("R7 overrun after reset", ovr, 0);

        // R1 pin-started conversion
        start(K_PIN);
        check_eq("R1 busy latency", busy, 1);
        run_op(0, 0, K_NONE, len);
        check_eq("R1 conv length", len, T_CONV);
        check_eq("R3 done at fall", done, 1);
        @(negedge clk);
        check_eq("R3 done one cycle", done, 0);

        // R9 software request
        start(K_SW);
        check_eq("R9 busy latency", busy, 1);
        run_op(0, 0, K_NONE, len);
        check_eq("R9 conv length", len, T_CONV);
        check_eq("R9 done", done, 1);
        @(negedge clk);

        // R2 every calibration select
        for (int s = 0; s < 4; s++) begin
            sel = 2'(s);
            start(K_CAL);
            check_eq("R2 busy latency", busy, 1);
            run_op(0, 0, K_NONE, len);
            check_eq("R2 cal length", len, exp_cal_len(s));
            check_eq("R3 done after cal", done, 1);
            @(negedge clk);
            check_eq("R3 done clears", done, 0);
            check_eq("R2 no overrun", ovr, 0);
        end

        // R4 request during conversion, every position
        for (int j = 1; j <= int'(T_CONV); j++) begin
            do_reset();
            check_eq("R7 overrun cleared", ovr, 0);
            start(K_SW);
            run_op(j, 0, K_SW, len);
            check_eq("R4 conv length kept", len, T_CONV);
            check_eq("R4 overrun set", ovr, 1);
            idle_for("R4 no queued conv", 3);
            check_eq("R4 overrun sticky", ovr, 1);
        end
        do_reset();
        start(K_SW);
        run_op(2, 0, K_PIN, len);
        check_eq("R4 pin during conv length", len, T_CONV);
        check_eq("R4 pin overrun", ovr, 1);

        // R5 request during offset calibration, every position incl. last
        for (int j = 1; j <= int'(T_OFFS); j++) begin
            do_reset();
            sel = 2'd2;
            start(K_CAL);
            run_op(j, 0, K_SW, len);
            check_eq("R5 cal length kept", len, T_OFFS);
            check_eq("R5 done in gap", done, 1);
            check_eq("R5 gap busy low", busy, 0);
            @(negedge clk);
            check_eq("R5 queued conv starts", busy, 1);
            run_op(0, 0, K_NONE, len);
            check_eq("R5 queued conv length", len, T_CONV);
            check_eq("R5 no overrun", ovr, 0);
        end

        // R5 second request while one is held
        do_reset();
        sel = 2'd1;
        start(K_CAL);
        run_op(2, 5, K_SW, len);
        check_eq("R5 cal length double", len, T_GAIN);
        check_eq("R5 double overrun", ovr, 1);
        @(negedge clk);
        run_op(0, 0, K_NONE, len);
        check_eq("R5 one conv after double", len, T_CONV);
        idle_for("R5 only one queued", 3);

        // R5 calibration and conversion requests on the same edge
        do_reset();
        sel = 2'd1;
        convst = 1'b1;
        cal    = 1'b1;
        @(negedge clk);
        clear_all();
        check_eq("R5 same-edge busy", busy, 1);
        run_op(0, 0, K_NONE, len);
        check_eq("R5 same-edge cal wins", len, T_GAIN);
        @(negedge clk);
        run_op(0, 0, K_NONE, len);
        check_eq("R5 same-edge conv follows", len, T_CONV);
        check_eq("R5 same-edge no overrun", ovr, 0);

        // R6 calibration request while busy
        do_reset();
        sel = 2'd0;
        start(K_SW);
        run_op(3, 0, K_CAL, len);
        check_eq("R6 conv length with cal", len, T_CONV);
        idle_for("R6 cal not started", 4);
        sel = 2'd2;
        start(K_CAL);
        run_op(4, 0, K_CAL, len);
        check_eq("R6 cal length with cal", len, T_OFFS);
        idle_for("R6 second cal not started", 4);
        check_eq("R6 no overrun", ovr, 0);

        // R8 back-to-back through done cycle
        start(K_SW);
        run_op(0, 0, K_NONE, len);
        check_eq("R8 done cycle busy low", busy, 0);
        sw = 1'b1;
        @(negedge clk);
        sw = 1'b0;
        check_eq("R8 restart after one low cycle", busy, 1);
        run_op(0, 0, K_NONE, len);
        check_eq("R8 second conv length", len, T_CONV);

        // R7 pin held high through reset release
        rst = 1'b1;
        convst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        idle_for("R7 held pin no start", 4);
        convst = 1'b0;
        @(negedge clk);
        convst = 1'b1;
        @(negedge clk);
        convst = 1'b0;
        check_eq("R7 fresh edge starts", busy, 1);
        run_op(0, 0, K_NONE, len);
        check_eq("R7 fresh conv length", len, T_CONV);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule